// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives 8-bit characters over a two-wire synchronous link: a serial clock and a data line, with no start or stop bits. Data bits are shifted into a shift register, least significant bit first, on each rising serial clock edge. When the eighth bit lands, the completed character moves into a read buffer and a receive-full flag is raised. The shift register and the buffer together form a double buffer, so the next character can arrive while software or a DMA engine empties the previous one.

The serial clock comes from one of two places. It can be an external clock on the clock pin, which is brought into the system clock domain through a synchronizer and an edge detector. It can also be an internal divider, which is then driven out on the clock pin and runs without a break for as long as receive is enabled. If a character completes while the buffer is still full, the character is dropped and an overrun flag is raised. No further characters are accepted until software clears that flag. Two interrupt requests report a full buffer and an overrun.

Software drives the block through a small register port. A DMA engine can read the buffer through a separate read strobe.

Top module: `sync_rx_unit`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 2) read 0, both interrupt outputs are 0 and `sclk_oe` is 0.
- R2: With receive enabled (control bit 0) and the external clock selected (control bit 2 = 0), the bit on `rxd` at each rising edge of `sclk_in` is shifted in LSB first. After the 8th edge, the byte is readable at data address 3 and status bit 0 (full) reads 1.
- R3: With receive enabled and the internal clock selected (control bit 2 = 1), `sclk_oe` is 1 and `sclk_out` toggles with a period of 2×(N+1) system clocks, where N is the divider register at address 1. When receive is disabled, `sclk_oe` is 0 and `sclk_out` is held low.
- R4: The full flag is cleared by a status read that returns it as 1, followed by a status write with bit 0 = 0. A write of 0 that has no such read before it leaves the flag set. Writing 1 to a status bit never sets it.
- R5: A pulse on `dma_rd` returns the buffer on `dma_data` and clears the full flag.
- R6: If the 8th bit of a byte arrives while the full flag is 1, status bit 1 (overrun) is set and the buffer keeps the older byte.
- R7: While the overrun flag is 1, serial clock edges are ignored and no byte is captured, even if the buffer is empty.
- R8: The overrun flag is cleared by a status read that returns it as 1, followed by a status write with bit 1 = 0.
- R9: `irq_rx_end` equals the full flag ANDed with the interrupt enable (control bit 1). `irq_rx_err` equals the overrun flag ANDed with that same enable.
- R10: Clearing receive enable part-way through a byte drops the partial byte. The next enable starts from bit 0, and the flags and the buffer are left unchanged.
- R11: Back-to-back bytes in internal-clock mode are all received if the buffer is emptied before the last bit of the following byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the clock pin (external mode) |
| sclk_out | output | 1 | Serial clock driven to the clock pin (internal mode) |
| sclk_oe | output | 1 | Output enable for the clock pin |
| rxd | input | 1 | Serial receive data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 divider, 2 status, 3 data |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| dma_rd | input | 1 | DMA read strobe; clears the full flag |
| dma_data | output | DATA_W | Receive buffer contents for DMA |
| irq_rx_end | output | 1 | Receive-complete interrupt request |
| irq_rx_err | output | 1 | Receive-overrun interrupt request |

## Verification
The bench uses the default parameters: 8 data bits, an 8-bit divider and a two-stage synchronizer. Random divider values from 0 to 7 give short internal clock periods. These make period measurements, back-to-back streams and overrun sequences cheap to run, and a divider of 0 exercises a clock that toggles every system cycle. The two-stage synchronizer keeps the external edge latency at three cycles, so mid-byte aborts and DMA reads can be placed between specific serial edges.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DIV  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_DATA = 2'd3
    } reg_addr_e;

    // bit 0 rx_en, bit 1 int_en, bit 2 clk_int
    typedef struct packed {
        logic clk_int;
        logic int_en;
        logic rx_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // bit 0 full, bit 1 overrun
    typedef struct packed {
        logic ovr;
        logic full;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        return c;
    endfunction

endpackage

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_int,
    input  logic             run_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             sclk_pin,
    input  logic             rxd_pin,
    output logic             sclk_int,
    output logic             sample,
    output logic             rxd_sync
);

    generate
        if (SYNC_STAGES < 2) begin : g_bad_sync
            $error("SYNC_STAGES must be at least 2");
        end
    endgenerate

    logic [DIV_W-1:0]       div_cnt;
    logic                   sclk_q;
    logic [SYNC_STAGES-1:0] ck_sh;
    logic [SYNC_STAGES-1:0] rx_sh;
    logic                   ck_prev;
    logic                   at_terminal;
    logic                   ext_rise;

    assign at_terminal = (div_cnt == div);

    // internal divider: half period is div+1 system clocks
    always_ff @(posedge clk) begin
        if (rst || !run_int) begin
            div_cnt <= '0;
            sclk_q  <= 1'b0;
        end else if (at_terminal) begin
            div_cnt <= '0;
            sclk_q  <= ~sclk_q;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // pin synchronizers, data delayed as much as the clock
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sh   <= '0;
            rx_sh   <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_sh   <= {ck_sh[SYNC_STAGES-2:0], sclk_pin};
            rx_sh   <= {rx_sh[SYNC_STAGES-2:0], rxd_pin};
            ck_prev <= ck_sh[SYNC_STAGES-1];
        end
    end

    assign ext_rise = ck_sh[SYNC_STAGES-1] & ~ck_prev;
    assign sample   = (run_int & at_terminal & ~sclk_q) | (run_ext & ext_rise);
    assign rxd_sync = rx_sh[SYNC_STAGES-1];
    assign sclk_int = sclk_q;

endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              hold,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word,
    output logic              done,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt_q;
    logic              take;

    assign take = enable & ~hold & sample;
    assign word = {bit_in, shreg[DATA_W-1:1]};
    assign done = take & (cnt_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt_q <= '0;
        end else if (!enable || hold) begin
            cnt_q <= '0;
        end else if (take) begin
            shreg <= word;
            cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_cnt = cnt_q;

endmodule

// File: rtl/sync_rx_regs.sv
module sync_rx_regs
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dma_rd,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div,
    output stat_t             stat,
    output logic [DATA_W-1:0] data_buf,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_addr_e addr;
    logic      wr_stat;
    logic      rd_stat;
    stat_t     armed;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_stat = reg_wr && (addr == ADDR_STAT);
    assign rd_stat = reg_rd && (addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= '0;
        end else if (reg_wr) begin
            if (addr == ADDR_CTRL) ctrl <= ctrl_from_word(reg_wdata[CTRL_W-1:0]);
            if (addr == ADDR_DIV)  div  <= reg_wdata[DIV_W-1:0];
        end
    end

    // flags and buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            stat     <= '0;
            data_buf <= '0;
        end else begin
            if (done && !stat.full) begin
                stat.full <= 1'b1;
                data_buf  <= word;
            end else if (dma_rd) begin
                stat.full <= 1'b0;
            end else if (wr_stat && !reg_wdata[0] && armed.full) begin
                stat.full <= 1'b0;
            end

            if (done && stat.full) begin
                stat.ovr <= 1'b1;
            end else if (wr_stat && !reg_wdata[1] && armed.ovr) begin
                stat.ovr <= 1'b0;
            end
        end
    end

    // a clear needs a prior status read that returned the flag as 1
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= '0;
        end else if (rd_stat) begin
            armed <= stat;
        end else if (wr_stat) begin
            armed <= '0;
        end else begin
            armed.full <= armed.full & stat.full;
            armed.ovr  <= armed.ovr & stat.ovr;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
            ADDR_DIV:  reg_rdata = DATA_W'(div);
            ADDR_STAT: reg_rdata = DATA_W'(stat);
            ADDR_DATA: reg_rdata = data_buf;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sync_rx_unit.sv
module sync_rx_unit
    import sync_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              rxd,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dma_rd,
    output logic [DATA_W-1:0] dma_data,
    output logic              irq_rx_end,
    output logic              irq_rx_err
);

    localparam int CNT_W = $clog2(DATA_W);

    ctrl_t             ctrl;
    stat_t             stat;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] data_buf;
    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              run_int;
    logic              run_ext;
    logic              sample;
    logic              rxd_sync;
    logic              done;
    logic              full;
    logic              ovr;
    logic              rx_en;

    assign rx_en   = ctrl.rx_en;
    assign run_int = ctrl.rx_en & ctrl.clk_int;
    assign run_ext = ctrl.rx_en & ~ctrl.clk_int;
    assign full    = stat.full;
    assign ovr     = stat.ovr;

    sync_rx_clkgen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) clkgen_i (
        .clk     (clk),
        .rst     (rst),
        .run_int (run_int),
        .run_ext (run_ext),
        .div     (div),
        .sclk_pin(sclk_in),
        .rxd_pin (rxd),
        .sclk_int(sclk_out),
        .sample  (sample),
        .rxd_sync(rxd_sync)
    );

    sync_rx_shifter #(
        .DATA_W(DATA_W)
    ) shifter_i (
        .clk    (clk),
        .rst    (rst),
        .enable (rx_en),
        .hold   (ovr),
        .sample (sample),
        .bit_in (rxd_sync),
        .word   (word),
        .done   (done),
        .bit_cnt(bit_cnt)
    );

    sync_rx_regs #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .dma_rd   (dma_rd),
        .done     (done),
        .word     (word),
        .ctrl     (ctrl),
        .div      (div),
        .stat     (stat),
        .data_buf (data_buf),
        .reg_rdata(reg_rdata)
    );

    assign sclk_oe    = run_int;
    assign dma_data   = data_buf;
    assign irq_rx_end = ctrl.int_en & full;
    assign irq_rx_err = ctrl.int_en & ovr;

endmodule

// File: rtl/sync_rx_checker.sv
module sync_rx_checker #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk_oe,
    input logic              sclk_out,
    input logic              dma_rd,
    input logic              done,
    input logic              full,
    input logic              ovr,
    input logic              rx_en,
    input logic [DATA_W-1:0] data_buf,
    input logic [CNT_W-1:0]  bit_cnt
);

    a_r2_full_after_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(done));

    a_r3_clock_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!sclk_oe && $past(!sclk_oe)) |-> !sclk_out);

    a_r5_dma_empties: assert property (@(posedge clk) disable iff (rst)
        (dma_rd && !done) |=> !full);

    a_r6_overrun_keeps_buffer: assert property (@(posedge clk) disable iff (rst)
        (done && full) |=> (ovr && $stable(data_buf)));

    a_r7_frozen_in_overrun: assert property (@(posedge clk) disable iff (rst)
        (ovr && $past(ovr)) |-> $stable(data_buf));

    a_r10_disable_resets_count: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (bit_cnt == '0));

endmodule

bind sync_rx_unit sync_rx_checker #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sclk_oe (sclk_oe),
    .sclk_out(sclk_out),
    .dma_rd  (dma_rd),
    .done    (done),
    .full    (full),
    .ovr     (ovr),
    .rx_en   (rx_en),
    .data_buf(data_buf),
    .bit_cnt (bit_cnt)
);

// File: tb/sync_rx_unit_tb.sv
module sync_rx_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sclk_out;
    logic       sclk_oe;
    logic       rxd = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       dma_rd = 1'b0;
    logic [7:0] dma_data;
    logic       irq_rx_end;
    logic       irq_rx_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_rx_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk_in),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe),
        .rxd       (rxd),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_rd    (dma_rd),
        .dma_data  (dma_data),
        .irq_rx_end(irq_rx_end),
        .irq_rx_err(irq_rx_err)
    );

    function automatic int exp_period(input int n);
        return 2 * (n + 1);
    endfunction

    function automatic logic [7:0] ctrl_word(input bit en, input bit ie, input bit ci);
        return {5'b0, ci, ie, en};
    endfunction

    function automatic logic [7:0] stat_word(input bit full, input bit ovr);
        return {6'b0, ovr, full};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic dma_read(output logic [7:0] d);
        @(negedge clk);
        dma_rd = 1'b1;
        #1 d = dma_data;
        @(negedge clk);
        dma_rd = 1'b0;
    endtask

    task automatic send_ext(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rxd = b[i];
            repeat (3) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic send_int(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            @(posedge sclk_out);
            #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] b0;
        logic [7:0] b1;
        int         n;
        time        t0;
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl", rd, 0);
        bus_read(2'd2, rd); check("R1 stat", rd, 0);
        check("R1 irq_end", irq_rx_end, 0);
        check("R1 irq_err", irq_rx_err, 0);
        check("R1 sclk_oe", sclk_oe, 0);

        // R2 R5 R9: random bytes on the external clock
        for (int k = 0; k < 6; k++) begin
            bit ie;
            ie = 1'($urandom);
            b0 = 8'($urandom);
            bus_write(2'd0, ctrl_word(1, ie, 0));
            send_ext(b0, 8);
            bus_read(2'd2, rd); check("R2 full set", rd, stat_word(1, 0));
            bus_read(2'd3, rd); check("R2 data", rd, b0);
            check("R9 irq_end", irq_rx_end, ie);
            dma_read(rd); check("R5 dma data", rd, b0);
            bus_read(2'd2, rd); check("R5 full cleared", rd, stat_word(0, 0));
            check("R9 irq_end low", irq_rx_end, 0);
        end

        // R4 clearing rules for the full flag
        b0 = 8'hA5;
        send_ext(b0, 8);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rd); check("R4 write without read", rd, stat_word(1, 0));
        bus_write(2'd2, 8'h02);
        bus_read(2'd2, rd); check("R4 read then write0", rd, stat_word(0, 0));
        bus_write(2'd2, 8'h03);
        bus_read(2'd2, rd); check("R4 write1 no set", rd, stat_word(0, 0));

        // R10 abort mid byte with full set; buffer kept
        b0 = 8'h3C;
        send_ext(b0, 8);
        send_ext(8'hFF, 5);
        bus_write(2'd0, ctrl_word(0, 0, 0));
        bus_read(2'd2, rd); check("R10 flags kept", rd, stat_word(1, 0));
        bus_write(2'd0, ctrl_word(1, 0, 0));
        dma_read(rd); check("R10 buffer kept", rd, b0);
        b1 = 8'h96;
        send_ext(b1, 8);
        dma_read(rd); check("R10 realigned byte", rd, b1);
        bus_write(2'd0, ctrl_word(0, 0, 0));
        check("R3 oe off in ext", sclk_oe, 0);

        // R3 internal clock period for several dividers
        for (int k = 0; k < 4; k++) begin
            n = (k == 0) ? 0 : int'($urandom % 8);
            bus_write(2'd1, 8'(n));
            bus_write(2'd0, ctrl_word(1, 0, 1));
            check("R3 oe on", sclk_oe, 1);
            @(posedge sclk_out);
            t0 = $time;
            @(posedge sclk_out);
            check("R3 period", int'(($time - t0) / 4), exp_period(n));
            bus_write(2'd0, ctrl_word(0, 0, 0));
            @(negedge clk);
            check("R3 idle low", sclk_out, 0);
            check("R3 oe off", sclk_oe, 0);
        end

        // R11 back-to-back internal stream with DMA service
        bus_write(2'd1, 8'd3);
        bus_write(2'd0, ctrl_word(1, 1, 1));
        b0 = 8'($urandom);
        b1 = 8'($urandom);
        send_int(b0);
        fork
            send_int(b1);
            begin
                repeat (3) @(negedge clk);
                dma_read(rd);
                check("R11 first byte", rd, b0);
            end
        join
        bus_read(2'd2, rd); check("R11 no overrun", rd, stat_word(1, 0));
        dma_read(rd); check("R11 second byte", rd, b1);

        // R6 R7 R8 R9 overrun sequence
        bus_write(2'd0, ctrl_word(0, 1, 1));
        bus_write(2'd0, ctrl_word(1, 1, 1));
        b0 = 8'h5A;
        send_int(b0);
        send_int(8'hC3);
        bus_read(2'd2, rd); check("R6 overrun set", rd, stat_word(1, 1));
        check("R9 irq_err", irq_rx_err, 1);
        dma_read(rd); check("R6 buffer kept", rd, b0);
        send_int(8'h81);
        bus_read(2'd2, rd); check("R7 nothing captured", rd, stat_word(0, 1));
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, ctrl_word(0, 1, 1));
        bus_read(2'd2, rd); check("R8 overrun cleared", rd, stat_word(0, 0));
        check("R9 irq_err low", irq_rx_err, 0);

        report();
    end

endmodule